// File: doc/BRIEF.md
# Systolic 4x4 Matrix Multiply Array

This block multiplies two small signed integer matrices on a square grid of multiply-accumulate cells. Each cell keeps its own result, so partial sums never move. One column of the left operand A enters per cycle on the left edge of the grid. In the same cycle, one row of the right operand B enters on the top edge. Each operand lane passes through a skew delay that grows with its index. Inside the grid, values travel one cell per cycle, A to the right and B downward. Because of the skew, the matching pair A[i][k] and B[k][j] meets in cell (i,j).

A single start pulse launches an operation. The controller then runs N load cycles and a fixed drain period, and takes a snapshot of every cell into an output bank. It then presents that bank one result column per cycle. The grid is free as soon as the snapshot is taken, so the next operation can begin while results are still leaving.

The block also handles several cases beyond a plain product:
- Three lane masks let it work on operands smaller than the grid.
- A preload operation writes a bias matrix straight into the cells.
- An accumulate flag keeps earlier results so that tiles can be summed across operations.
- A manual shift mode holds each output column until the consumer asks for the next one.

Top module: `systolic_mm4`

## Requirements
- R1: After reset, `c_valid` and `done` are 0 and stay 0 until a multiply result is produced.
- R2: A multiply started with all masks set yields C = A x B as signed 48-bit values. A column k goes on `a_col` in the k-th cycle of the operation, counting the start cycle as cycle 0, with A[i][k] at bits [16i+15:16i]. Row k of B goes on `b_row` in the same cycle, with B[k][j] at bits [16j+15:16j]. Result column j is presented on `c_col` with C[i][j] at bits [48i+47:48i]. In automatic mode, columns 0,1,2,3 are valid in cycles 12,13,14,15.
- R3: `row_mask[i]`, `inner_mask[k]` and `col_mask[j]` are sampled in the start cycle. A[i][k] contributes only when row bit i and inner bit k are set. B[k][j] contributes only when inner bit k and column bit j are set. Any masked element counts as zero, whatever value is driven.
- R4: A multiply started with `accumulate`=1 adds its product to the results left in the cells instead of clearing them first.
- R5: A start with `preload`=1 takes bias column k from `a_col` in its k-th cycle, with row i at bits [16i+15:16i]. It produces no output. The next multiply adds its product to that bias even with `accumulate`=0.
- R6: With `manual_shift`=1, the presented column stays valid and unchanged until a cycle with `shift_next`=1. While unread columns remain, a later operation that has finished computing waits and does not overwrite them.
- R7: `done` is high for exactly one cycle: the cycle after the last result column of an operation was taken.
- R8: A start is accepted while idle, or in the cycle in which the current multiply finishes computing, which is cycle 11 of that multiply. A start at any other time during a busy operation is ignored and its operand data has no effect.
- R9: Products of the extreme value -32768 accumulate over several tiles without overflow inside the 48-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation launch |
| preload | input | 1 | Sampled at start: 1 = bias load, 0 = multiply |
| accumulate | input | 1 | Sampled at start: keep previous results |
| manual_shift | input | 1 | 1 = each output column waits for `shift_next` |
| shift_next | input | 1 | Request to advance to the next output column |
| row_mask | input | N | Valid rows of A |
| inner_mask | input | N | Valid columns of A / rows of B |
| col_mask | input | N | Valid columns of B |
| a_col | input | N*DW | One column of A (or of the bias) per cycle |
| b_row | input | N*DW | One row of B per cycle |
| c_col | output | N*AW | One result column |
| c_valid | output | 1 | `c_col` holds a valid column |
| done | output | 1 | Operation fully shifted out |

## Verification
The bench targets the cycle in which results appear. A skew or drain count that is off by one either shifts the first valid column away from cycle 12 or pairs the wrong operand elements, and the sums come out wrong.

Masked operands are driven with large nonzero values in their masked positions, so a mask that gates only one operand, or none, makes those values appear in the sums. Back-to-back starts, a start pulse while busy, and a second result that is ready while manual-mode columns are still unread all stress the output bank. A design that snapshots too early, accepts the stray start, or overwrites held columns delivers columns that do not match the expected queue.

Bias followed by a non-accumulating multiply, and repeated tiles of -32768 operands, expose a clear that ignores the pending bias, and an accumulator that is too narrow.

// File: rtl/systolic_mm4.sv
module systolic_mm4 #(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          preload,
  input  logic          accumulate,
  input  logic          manual_shift,
  input  logic          shift_next,
  input  logic [N-1:0]  row_mask,
  input  logic [N-1:0]  inner_mask,
  input  logic [N-1:0]  col_mask,
  input  logic [N*DW-1:0] a_col,
  input  logic [N*DW-1:0] b_row,
  output logic [N*AW-1:0] c_col,
  output logic          c_valid,
  output logic          done
);
  localparam int LAST = 3*N - 2;
  localparam int CW   = $clog2(LAST + 1);
  localparam int KW   = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(LAST);
  localparam logic [CW-1:0] CNT_LOAD = CW'(N - 1);
  localparam logic [CW-1:0] CNT_PRE  = CW'(N - 2);
  localparam logic [KW-1:0] PTR_END  = KW'(N - 1);

  logic busy, pre_op, bias_pend, ob_busy;
  logic fin, go, go_mul, go_pre, loading, pre_wr, adv, in_ok, keep;
  logic [CW-1:0] cnt, kidx;
  logic [KW-1:0] ptr;
  logic [N-1:0] rm_q, im_q, cm_q, rm, im, cm;
  logic [N*DW-1:0] a_g, b_g;
  logic [N*N*DW-1:0] a_cell, b_cell;
  logic [N*AW-1:0] ob_col [N];

  assign fin     = busy && !pre_op && cnt == CNT_LAST && !ob_busy;
  assign go      = start && (!busy || fin);
  assign go_mul  = go && !preload;
  assign go_pre  = go && preload;
  assign kidx    = go ? '0 : cnt + 1'b1;
  assign rm      = go ? row_mask   : rm_q;
  assign im      = go ? inner_mask : im_q;
  assign cm      = go ? col_mask   : cm_q;
  assign loading = go_mul || (busy && !pre_op && cnt < CNT_LOAD);
  assign pre_wr  = go_pre || (busy && pre_op && cnt < CNT_LOAD);
  assign in_ok   = loading && im[kidx[KW-1:0]];
  assign keep    = accumulate || bias_pend;
  assign adv     = ob_busy && (!manual_shift || shift_next);
  assign c_valid = ob_busy;
  assign c_col   = ob_col[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; pre_op <= 1'b0; bias_pend <= 1'b0; cnt <= '0;
      rm_q <= '0; im_q <= '0; cm_q <= '0;
    end else if (go) begin
      busy <= 1'b1; pre_op <= preload; cnt <= '0;
      rm_q <= row_mask; im_q <= inner_mask; cm_q <= col_mask;
      if (!preload) bias_pend <= 1'b0;
    end else if (busy) begin
      if (pre_op && cnt == CNT_PRE) begin
        busy <= 1'b0;
        bias_pend <= 1'b1;
      end else if (fin) begin
        busy <= 1'b0;
      end else if (cnt != CNT_LAST) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_busy <= 1'b0; ptr <= '0; done <= 1'b0;
    end else begin
      done <= adv && ptr == PTR_END;
      if (fin) begin
        ob_busy <= 1'b1;
        ptr <= '0;
      end else if (adv) begin
        ptr <= ptr + 1'b1;
        if (ptr == PTR_END) ob_busy <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_arow
    logic [(i+N)*DW-1:0] ach;
    assign a_g[i*DW +: DW] = (in_ok && rm[i]) ? a_col[i*DW +: DW] : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) ach <= '0;
      else        ach <= {ach[(i+N-1)*DW-1:0], a_g[i*DW +: DW]};
    end
    for (genvar j = 0; j < N; j++) begin : g_tap
      assign a_cell[(i*N+j)*DW +: DW] = ach[(i+j)*DW +: DW];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_bcol
    logic [(j+N)*DW-1:0] bch;
    assign b_g[j*DW +: DW] = (in_ok && cm[j]) ? b_row[j*DW +: DW] : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) bch <= '0;
      else        bch <= {bch[(j+N-1)*DW-1:0], b_g[j*DW +: DW]};
    end
    for (genvar i = 0; i < N; i++) begin : g_tap
      assign b_cell[(i*N+j)*DW +: DW] = bch[(i+j)*DW +: DW];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_cell
      logic signed [DW-1:0]   av, bv;
      logic signed [2*DW-1:0] pr;
      logic signed [AW-1:0]   acc, ob;
      assign av = a_cell[(i*N+j)*DW +: DW];
      assign bv = b_cell[(i*N+j)*DW +: DW];
      assign pr = av * bv;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc <= '0; ob <= '0;
        end else begin
          if (fin) ob <= acc;
          if (pre_wr && kidx[KW-1:0] == KW'(j))
            acc <= AW'($signed(a_col[i*DW +: DW]));
          else if (go_mul && !keep)
            acc <= '0;
          else
            acc <= acc + AW'(pr);
        end
      end
      assign ob_col[j][i*AW +: AW] = ob;
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && manual_shift && !shift_next) |=> (c_valid && $stable(c_col)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c_valid) |-> done);

  a_r5_preload_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pre_op) |=> !$rose(c_valid));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !pre_op && !fin && cnt != CNT_LAST) |=> (cnt != '0));
endmodule

// File: tb/tb_systolic_mm4.sv
`timescale 1ns/1ps
module tb_systolic_mm4;
  localparam int N = 4, DW = 16, AW = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, preload = 1'b0, accumulate = 1'b0;
  logic manual_shift = 1'b0, shift_next = 1'b0;
  logic [N-1:0] row_mask = '0, inner_mask = '0, col_mask = '0;
  logic [N*DW-1:0] a_col = '0, b_row = '0;
  logic [N*AW-1:0] c_col;
  logic c_valid, done;

  always #2.5 clk = ~clk;

  systolic_mm4 #(.N(N), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .preload(preload),
    .accumulate(accumulate), .manual_shift(manual_shift), .shift_next(shift_next),
    .row_mask(row_mask), .inner_mask(inner_mask), .col_mask(col_mask),
    .a_col(a_col), .b_row(b_row), .c_col(c_col), .c_valid(c_valid), .done(done));

  int total = 0, fails = 0, cyc = 0, start_cyc = 0, n_mul = 0, n_done = 0;
  bit exp_done = 1'b0, bias_pend = 1'b0;
  longint model [N][N];
  logic [N*AW-1:0] exp_q [$];
  bit last_q [$];
  string tag_q [$];
  int A [N][N], B [N][N], P [N][N];
  localparam logic [N-1:0] FULL = '1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input logic [N*AW-1:0] act, input logic [N*AW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) n_done++;
      if (exp_done) begin
        chk(done == 1'b1, "R7 done after last column", {191'd0, done}, 1);
        exp_done = 1'b0;
      end else if (done) begin
        chk(1'b0, "R7 stray done", 1, 0);
      end
      if (c_valid && (!manual_shift || shift_next)) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected column", c_col, 0);
        else begin
          chk(c_col == exp_q[0], tag_q[0], c_col, exp_q[0]);
          exp_done = last_q[0];
          void'(exp_q.pop_front());
          void'(last_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic issue(input int a [N][N], input int b [N][N],
                       input logic [N-1:0] rm, input logic [N-1:0] im,
                       input logic [N-1:0] cm, input bit acc_en, input bit pre,
                       input string tag);
    if (pre) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) model[i][j] = longint'(a[i][j]);
      bias_pend = 1'b1;
    end else begin
      if (!(acc_en || bias_pend))
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) model[i][j] = 0;
      bias_pend = 1'b0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          for (int k = 0; k < N; k++) begin
            longint x, y;
            x = (rm[i] && im[k]) ? longint'(a[i][k]) : 0;
            y = (im[k] && cm[j]) ? longint'(b[k][j]) : 0;
            model[i][j] += x * y;
          end
      for (int j = 0; j < N; j++) begin
        logic [N*AW-1:0] col;
        for (int i = 0; i < N; i++) col[i*AW +: AW] = model[i][j][AW-1:0];
        exp_q.push_back(col);
        last_q.push_back(j == N-1);
        tag_q.push_back(tag);
      end
      n_mul++;
    end
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1;
      if (k == 0) start_cyc = cyc;
      start = (k == 0); preload = pre; accumulate = acc_en;
      row_mask = rm; inner_mask = im; col_mask = cm;
      for (int i = 0; i < N; i++) begin
        a_col[i*DW +: DW] = a[i][k][DW-1:0];
        b_row[i*DW +: DW] = b[k][i][DW-1:0];
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      start = 1'b0; a_col = '0; b_row = '0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!c_valid && !done, "R1 reset state", {190'd0, c_valid, done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(3);
    chk(!c_valid && !done, "R1 idle after reset", {190'd0, c_valid, done}, 0);

    // R2: full product and output timing
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        A[i][j] = (i + 1) * 100 - j * 333;
        B[i][j] = 7 * j - 50 * i + 3;
      end
    issue(A, B, FULL, FULL, FULL, 1'b0, 1'b0, "R2 full product");
    while (cyc != start_cyc + 11) @(negedge clk);
    chk(!c_valid, "R2 no column in cycle 11", {191'd0, c_valid}, 0);
    @(negedge clk);
    chk(c_valid, "R2 first column in cycle 12", {191'd0, c_valid}, 1);
    idle(12);

    // R3: masked 3x2 by 2x4 with junk in masked lanes
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        A[i][j] = 1000 + i * 17 + j * 301;
        B[i][j] = -2000 + i * j * 9 - j;
      end
    issue(A, B, 4'b0111, 4'b0011, 4'b1111, 1'b0, 1'b0, "R3 masked operands");
    idle(16);

    // R4: accumulate on top of previous result
    issue(B, A, FULL, 4'b1010, 4'b0110, 1'b1, 1'b0, "R4 tile accumulate");
    idle(16);

    // R5: bias preload then plain multiply
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) P[i][j] = i * 10 - j * 1000 + 5;
    issue(P, A, FULL, FULL, FULL, 1'b0, 1'b1, "R5 preload");
    @(negedge clk);
    chk(!c_valid, "R5 preload gives no output", {191'd0, c_valid}, 0);
    issue(A, B, FULL, FULL, FULL, 1'b0, 1'b0, "R5 bias added");
    idle(16);

    // R8: start in the finishing cycle, then a stray start while busy
    issue(A, B, FULL, FULL, FULL, 1'b0, 1'b0, "R8 first operation");
    idle(7);
    issue(B, A, FULL, FULL, FULL, 1'b0, 1'b0, "R8 overlapped start, stray start ignored");
    idle(2);
    @(posedge clk); #1;
    start = 1'b1; preload = 1'b0; accumulate = 1'b0;
    a_col = '1; b_row = '1;
    idle(24);

    // R6: manual shift hold and stalled second result
    @(posedge clk); #1 manual_shift = 1'b1;
    issue(A, B, FULL, FULL, FULL, 1'b0, 1'b0, "R6 manual first");
    idle(14);
    @(negedge clk);
    chk(c_valid && c_col == exp_q[0], "R6 column held", c_col, exp_q[0]);
    issue(B, A, 4'b1101, FULL, 4'b0111, 1'b0, 1'b0, "R6 manual stalled second");
    idle(14);
    @(negedge clk);
    chk(c_valid && c_col == exp_q[0], "R6 held while second waits", c_col, exp_q[0]);
    repeat (12) begin
      @(posedge clk); #1 shift_next = 1'b1;
      @(posedge clk); #1 shift_next = 1'b0;
    end
    @(posedge clk); #1 manual_shift = 1'b0;
    idle(8);

    // R9: extreme values over three tiles
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        A[i][j] = -32768;
        B[i][j] = (j == 1) ? 32767 : -32768;
      end
    issue(A, B, FULL, FULL, FULL, 1'b0, 1'b0, "R9 extreme tile 1");
    idle(12);
    issue(A, B, FULL, FULL, FULL, 1'b1, 1'b0, "R9 extreme tile 2");
    idle(12);
    issue(A, B, FULL, FULL, FULL, 1'b1, 1'b0, "R9 extreme tile 3");
    idle(20);

    chk(exp_q.size() == 0, "R2 all expected columns produced", exp_q.size(), 0);
    chk(n_done == n_mul, "R7 one done per multiply", n_done, n_mul);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule